// File: doc/BRIEF.md
# ADC Scan, Pacing and Trigger Sequencer

This block decides when an analog-to-digital converter starts a conversion and which input channel the converter sees. A configuration write latches a first and a last channel number, a front-end mode (single-ended with sixteen inputs or differential with eight), a pacing source code and a trigger source code. The write also points the multiplexer address at the first channel. Each time the converter reports a finished conversion, the address moves up by one. After the last channel it returns to the first. When the last channel number is below the first, the count passes through the top of the channel space.

A conversion can be paced by a software write strobe, by an internal two-stage programmable divider of a reference tick, or by either edge of an external pacing pin. The pacing is gated by the trigger selection. Trigger code 01 lets pacing through at all times. Trigger code 10, with the trigger enable set, waits for the first rising edge on the external trigger pin. That edge sets a one-shot latch, which stays set until a clear strobe. Both external pins pass through a two-flop synchronizer. A conversion start is refused while the previous conversion is still busy, and also within a minimum spacing derived from the 330 kHz maximum conversion rate. A refused pacing event is dropped, not queued.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, mux_addr is 0, conv_start is 0, eoc is 1 and xtrig is 0. The latched configuration is differential mode, pacing code 00 and trigger code 00.
- R2: A cycle with cfg_wr high latches all cfg_* fields. On the next edge, mux_addr equals cfg_lo_ch masked to 4 bits in single-ended mode (cfg_single=1) or to its low 3 bits in differential mode (cfg_single=0).
- R3: mux_addr changes only on cfg_wr, or on the clock edge that samples conv_done high while a conversion is busy. At that edge it becomes the latched first channel if it equaled the latched last channel. Otherwise it becomes mux_addr+1 modulo 16 (single-ended) or modulo 8 (differential). In differential mode bit 3 stays 0.
- R4: With pacing code 00, each one-cycle sw_conv_wr pulse accepted by the gate starts exactly one conversion. conv_start is high for the one cycle after the edge that samples the pulse.
- R5: With pacing code 01, the internal divider produces one pacing event every L×U reference ticks. L is the lower and U is the upper 16-bit divisor. Each divisor is written as two div_wr bytes, low byte first: div_upper=0 selects the lower divisor and div_upper=1 the upper divisor. A divisor of 0 counts as 65536.
- R6: Pacing code 11 starts one conversion per rising edge of ext_pace, and code 10 one per falling edge. Edges of the other polarity start nothing.
- R7: Trigger codes 00 and 11 block every conversion. Trigger code 01 passes pacing events without condition.
- R8: With trigger code 10, conversions run only while xtrig is 1. With cfg_trig_en=1, the first rising edge of ext_trig sets xtrig. Later edges change nothing. xtrig_clr clears xtrig on the next edge. With cfg_trig_en=0, edges never set xtrig.
- R9: eoc is 0 from the cycle conv_start is high until the edge after conv_done is sampled. Pacing events that arrive while eoc is 0 are dropped and never start a later conversion.
- R10: Two conversion starts are never closer than MIN_GAP = ceil(CLK_HZ/MAX_RATE_HZ) cycles. Pacing events inside that window are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Latch all configuration fields and reload the channel address |
| cfg_lo_ch | input | 4 | First channel of the scan |
| cfg_hi_ch | input | 4 | Last channel of the scan |
| cfg_single | input | 1 | 1 = single-ended (16 inputs), 0 = differential (8 inputs) |
| cfg_pace | input | 2 | Pacing source: 00 software, 01 internal divider, 10 external falling, 11 external rising |
| cfg_trig | input | 2 | Trigger source: 00 off, 01 free run, 10 external one-shot, 11 off |
| cfg_trig_en | input | 1 | Arms the external trigger latch |
| div_wr | input | 1 | Divisor byte write strobe |
| div_upper | input | 1 | 0 = lower divisor stage, 1 = upper divisor stage |
| div_byte | input | 8 | Divisor byte (low byte first, then high byte) |
| ref_tick | input | 1 | Reference tick enable that clocks the internal divider |
| sw_conv_wr | input | 1 | Software conversion strobe, used with pacing code 00 |
| xtrig_clr | input | 1 | Clears the external trigger latch |
| ext_pace | input | 1 | Asynchronous external pacing pin |
| ext_trig | input | 1 | Asynchronous external trigger pin |
| conv_done | input | 1 | One-cycle end-of-conversion pulse from the converter |
| mux_addr | output | 4 | Channel address for the input multiplexer |
| conv_start | output | 1 | One-cycle conversion start pulse |
| eoc | output | 1 | 1 = converter idle, 0 = conversion busy (not latched) |
| xtrig | output | 1 | State of the external trigger latch |

## Verification
The bench builds the block with CLK_HZ = 1,980,000, which makes MIN_GAP six cycles. At that spacing the software-paced scan can sweep every first/last channel pair, 256 in single-ended mode and 64 in differential mode, including the pairs that wrap through the top of the channel space. The short spacing also puts the gap limit within reach of the internal divider: divisors 1×2 give a pacing event every second cycle, so starts must fall exactly six cycles apart, while divisors 3×4 give starts exactly twelve cycles apart. A converter model in the bench, with a programmable latency, exposes the busy window so the bench can show that pacing events arriving inside it are dropped.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  localparam int CH_W = 4;

  typedef enum logic [1:0] {
    PACE_SW    = 2'b00,
    PACE_INT   = 2'b01,
    PACE_XFALL = 2'b10,
    PACE_XRISE = 2'b11
  } pace_src_e;

  typedef enum logic [1:0] {
    TRG_OFF = 2'b00,
    TRG_SW  = 2'b01,
    TRG_EXT = 2'b10,
    TRG_RSV = 2'b11
  } trig_src_e;

  typedef struct packed {
    logic            single;
    pace_src_e       pace;
    trig_src_e       trig;
    logic            trig_en;
    logic [CH_W-1:0] hi;
    logic [CH_W-1:0] lo;
  } seq_cfg_t;

  // Address bits in use: all of them single-ended, one fewer differential.
  function automatic logic [CH_W-1:0] chan_mask(input logic single);
    return single ? {CH_W{1'b1}} : {1'b0, {(CH_W-1){1'b1}}};
  endfunction

  // Next scan channel: back to the first after the last, else step up.
  function automatic logic [CH_W-1:0] chan_next(input logic [CH_W-1:0] cur,
                                                input logic [CH_W-1:0] lo,
                                                input logic [CH_W-1:0] hi,
                                                input logic            single);
    logic [CH_W-1:0] m;
    m = chan_mask(single);
    if ((cur & m) == (hi & m)) return lo & m;
    return (cur + CH_W'(1)) & m;
  endfunction

endpackage

// File: rtl/adc_sync_edge.sv
module adc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  input  logic rise_sel,
  output logic edge_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], async_in};
  end

  logic sync_now, sync_prev;
  assign sync_now  = sh_q[STAGES-1];
  assign sync_prev = sh_q[STAGES];
  assign edge_o    = rise_sel ? (sync_now & ~sync_prev) : (~sync_now & sync_prev);
endmodule

// File: rtl/adc_div_stage.sv
module adc_div_stage #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr,
  input  logic [BYTE_W-1:0] wbyte,
  output logic              tc
);
  localparam int DIV_W = 2 * BYTE_W;

  logic [DIV_W-1:0]  reload_q, cnt_q;
  logic [BYTE_W-1:0] low_q;
  logic              high_next_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q    <= '0;
      cnt_q       <= '0;
      low_q       <= '0;
      high_next_q <= 1'b0;
    end else if (wr) begin
      if (!high_next_q) begin
        low_q       <= wbyte;
        high_next_q <= 1'b1;
      end else begin
        reload_q    <= {wbyte, low_q};
        cnt_q       <= {wbyte, low_q};
        high_next_q <= 1'b0;
      end
    end else if (en) begin
      if (cnt_q == DIV_W'(1)) cnt_q <= reload_q;
      else                    cnt_q <= cnt_q - DIV_W'(1);
    end
  end

  // A zero divisor runs through the whole counter range: period 2**DIV_W.
  assign tc = en && !wr && (cnt_q == DIV_W'(1));
endmodule

// File: rtl/adc_pacer_div.sv
module adc_pacer_div #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              wr,
  input  logic              sel_upper,
  input  logic [BYTE_W-1:0] wbyte,
  output logic              tick
);
  localparam int N_STG = 2;

  logic [N_STG:0] chain;
  assign chain[0] = ref_tick;

  for (genvar s = 0; s < N_STG; s++) begin : g_stage
    logic stage_wr;
    assign stage_wr = wr && (sel_upper == 1'(s));
    adc_div_stage #(.BYTE_W(BYTE_W)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (chain[s]),
      .wr    (stage_wr),
      .wbyte (wbyte),
      .tc    (chain[s+1])
    );
  end

  assign tick = chain[N_STG];
endmodule

// File: rtl/adc_scan_addr.sv
module adc_scan_addr
  import adc_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [CH_W-1:0] load_ch,
  input  logic            load_single,
  input  logic            adv,
  input  logic [CH_W-1:0] lo,
  input  logic [CH_W-1:0] hi,
  input  logic            single,
  output logic [CH_W-1:0] addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= load_ch & chan_mask(load_single);
    else if (adv)  addr <= chan_next(addr, lo, hi, single);
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CLK_HZ      = 125_000_000,
  parameter int MAX_RATE_HZ = 330_000,
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CH_W-1:0]   cfg_lo_ch,
  input  logic [CH_W-1:0]   cfg_hi_ch,
  input  logic              cfg_single,
  input  logic [1:0]        cfg_pace,
  input  logic [1:0]        cfg_trig,
  input  logic              cfg_trig_en,
  input  logic              div_wr,
  input  logic              div_upper,
  input  logic [BYTE_W-1:0] div_byte,
  input  logic              ref_tick,
  input  logic              sw_conv_wr,
  input  logic              xtrig_clr,
  input  logic              ext_pace,
  input  logic              ext_trig,
  input  logic              conv_done,
  output logic [CH_W-1:0]   mux_addr,
  output logic              conv_start,
  output logic              eoc,
  output logic              xtrig
);
  localparam int MIN_GAP = (CLK_HZ + MAX_RATE_HZ - 1) / MAX_RATE_HZ;
  localparam int GAP_W   = $clog2(MIN_GAP + 1);

  // ---------------- configuration ----------------
  seq_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (cfg_wr) begin
      cfg_q.single  <= cfg_single;
      cfg_q.pace    <= pace_src_e'(cfg_pace);
      cfg_q.trig    <= trig_src_e'(cfg_trig);
      cfg_q.trig_en <= cfg_trig_en;
      cfg_q.hi      <= cfg_hi_ch;
      cfg_q.lo      <= cfg_lo_ch;
    end
  end

  logic      cfg_single_q;
  trig_src_e trig_mode_q;
  assign cfg_single_q = cfg_q.single;
  assign trig_mode_q  = cfg_q.trig;

  // ---------------- event sources ----------------
  logic ext_pace_edge, ext_trig_rise, int_tick;

  adc_sync_edge #(.STAGES(SYNC_STAGES)) u_pace_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (ext_pace),
    .rise_sel (cfg_q.pace == PACE_XRISE),
    .edge_o   (ext_pace_edge)
  );

  adc_sync_edge #(.STAGES(SYNC_STAGES)) u_trig_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (ext_trig),
    .rise_sel (1'b1),
    .edge_o   (ext_trig_rise)
  );

  adc_pacer_div #(.BYTE_W(BYTE_W)) u_pacer (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_tick  (ref_tick),
    .wr        (div_wr),
    .sel_upper (div_upper),
    .wbyte     (div_byte),
    .tick      (int_tick)
  );

  logic pace_tick;
  always_comb begin
    unique case (cfg_q.pace)
      PACE_SW:  pace_tick = sw_conv_wr;
      PACE_INT: pace_tick = int_tick;
      default:  pace_tick = ext_pace_edge;
    endcase
  end

  // ---------------- trigger latch ----------------
  logic xtrig_q, xtrig_set;
  assign xtrig_set = ext_trig_rise && cfg_q.trig_en && (cfg_q.trig == TRG_EXT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         xtrig_q <= 1'b0;
    else if (xtrig_clr) xtrig_q <= 1'b0;
    else if (xtrig_set) xtrig_q <= 1'b1;
  end

  logic gate_open;
  always_comb begin
    unique case (cfg_q.trig)
      TRG_SW:  gate_open = 1'b1;
      TRG_EXT: gate_open = xtrig_q;
      default: gate_open = 1'b0;
    endcase
  end

  // ---------------- start arbitration ----------------
  logic             busy_q, start_q;
  logic [GAP_W-1:0] gap_q;
  logic             gap_ok, start_req, conv_fin;

  assign gap_ok    = (gap_q == '0);
  assign start_req = pace_tick && gate_open && !busy_q && gap_ok;
  assign conv_fin  = conv_done && busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      gap_q   <= '0;
    end else begin
      start_q <= start_req;
      if (start_req)     busy_q <= 1'b1;
      else if (conv_fin) busy_q <= 1'b0;
      if (start_req)     gap_q <= GAP_W'(MIN_GAP - 1);
      else if (!gap_ok)  gap_q <= gap_q - GAP_W'(1);
    end
  end

  // ---------------- channel scan ----------------
  adc_scan_addr u_scan (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (cfg_wr),
    .load_ch     (cfg_lo_ch),
    .load_single (cfg_single),
    .adv         (conv_fin),
    .lo          (cfg_q.lo),
    .hi          (cfg_q.hi),
    .single      (cfg_q.single),
    .addr        (mux_addr)
  );

  assign conv_start = start_q;
  assign eoc        = !busy_q;
  assign xtrig      = xtrig_q;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
  import adc_seq_pkg::*;
#(
  parameter int MIN_GAP = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            conv_start,
  input logic            conv_done,
  input logic            eoc,
  input logic            cfg_wr,
  input logic [CH_W-1:0] mux_addr,
  input logic            xtrig,
  input logic            xtrig_clr,
  input logic            cfg_single_q,
  input trig_src_e       trig_mode_q
);
  localparam int SW = $clog2(MIN_GAP + 1) + 1;
  logic [SW-1:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     since_q <= SW'(MIN_GAP);
    else if (conv_start)            since_q <= SW'(1);
    else if (since_q < SW'(MIN_GAP)) since_q <= since_q + SW'(1);
  end

  AST_EOC_LOW_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !eoc); // R9
  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!eoc && !conv_done) |=> !conv_start); // R9
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!conv_done && !cfg_wr) |=> $stable(mux_addr)); // R3
  AST_DIFF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_single_q |-> !mux_addr[CH_W-1]); // R3
  AST_XTRIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (xtrig && !xtrig_clr) |=> xtrig); // R8
  AST_XTRIG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    xtrig_clr |=> !xtrig); // R8
  AST_EXT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_mode_q == TRG_EXT && !xtrig) |=> !conv_start); // R8
  AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_mode_q == TRG_OFF || trig_mode_q == TRG_RSV) |=> !conv_start); // R7
  AST_MIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (since_q >= SW'(MIN_GAP))); // R10
endmodule

bind adc_seq_ctrl adc_seq_chk #(.MIN_GAP(MIN_GAP)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .conv_start   (conv_start),
  .conv_done    (conv_done),
  .eoc          (eoc),
  .cfg_wr       (cfg_wr),
  .mux_addr     (mux_addr),
  .xtrig        (xtrig),
  .xtrig_clr    (xtrig_clr),
  .cfg_single_q (cfg_single_q),
  .trig_mode_q  (trig_mode_q)
);

// File: tb/sim_adc_seq_ctrl.sv
`timescale 1ns/1ps
module sim_adc_seq_ctrl;
  localparam int RATE  = 330_000;
  localparam int GAP   = 6;
  localparam int CLKHZ = GAP * RATE;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 0, cfg_single = 0, cfg_trig_en = 0;
  logic [3:0] cfg_lo_ch = 0, cfg_hi_ch = 0;
  logic [1:0] cfg_pace = 0, cfg_trig = 0;
  logic       div_wr = 0, div_upper = 0;
  logic [7:0] div_byte = 0;
  logic       ref_tick = 1, sw_conv_wr = 0, xtrig_clr = 0;
  logic       ext_pace = 0, ext_trig = 0, conv_done = 0;
  logic [3:0] mux_addr;
  logic       conv_start, eoc, xtrig;

  adc_seq_ctrl #(.CLK_HZ(CLKHZ), .MAX_RATE_HZ(RATE)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_lo_ch(cfg_lo_ch),
    .cfg_hi_ch(cfg_hi_ch), .cfg_single(cfg_single), .cfg_pace(cfg_pace),
    .cfg_trig(cfg_trig), .cfg_trig_en(cfg_trig_en), .div_wr(div_wr),
    .div_upper(div_upper), .div_byte(div_byte), .ref_tick(ref_tick),
    .sw_conv_wr(sw_conv_wr), .xtrig_clr(xtrig_clr), .ext_pace(ext_pace),
    .ext_trig(ext_trig), .conv_done(conv_done), .mux_addr(mux_addr),
    .conv_start(conv_start), .eoc(eoc), .xtrig(xtrig));

  always #4 clk = ~clk;

  int nchk = 0, nerr = 0;
  int cyc = 0, nstart = 0, last_addr = 0, last_cyc = -1;
  int min_iv = 1 << 30, max_iv = 0;
  int done_lat = 2, dcnt = 0;

  // Converter model and start monitor, both on the falling edge.
  always @(negedge clk) begin
    cyc = cyc + 1;
    conv_done = 1'b0;
    if (conv_start) begin
      nstart = nstart + 1;
      last_addr = int'(mux_addr);
      if (last_cyc >= 0) begin
        if (cyc - last_cyc < min_iv) min_iv = cyc - last_cyc;
        if (cyc - last_cyc > max_iv) max_iv = cyc - last_cyc;
      end
      last_cyc = cyc;
      dcnt = done_lat;
    end else if (dcnt > 0) begin
      dcnt = dcnt - 1;
      if (dcnt == 0) conv_done = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic ncyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input int lo, input int hi, input bit single,
                     input int pace, input int trig, input bit ten);
    @(negedge clk);
    cfg_lo_ch = 4'(lo); cfg_hi_ch = 4'(hi); cfg_single = single;
    cfg_pace = 2'(pace); cfg_trig = 2'(trig); cfg_trig_en = ten; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic sw_pulse();
    @(negedge clk); sw_conv_wr = 1'b1;
    @(negedge clk); sw_conv_wr = 1'b0;
  endtask

  task automatic div_put(input bit upper, input int b);
    @(negedge clk); div_wr = 1'b1; div_upper = upper; div_byte = 8'(b);
    @(negedge clk); div_wr = 1'b0;
  endtask

  task automatic clear_iv();
    min_iv = 1 << 30; max_iv = 0; last_cyc = -1;
  endtask

  // k-th channel of a scan, written as an offset into a ring of length len.
  function automatic int ring_ch(input int lo, input int hi, input int k, input int n);
    int len;
    len = ((hi - lo) % n + n) % n + 1;
    return (lo + (k % len)) % n;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    ncyc(3);
    // R1 reset state
    chk(mux_addr == 0, "R1 mux_addr", int'(mux_addr), 0);
    chk(conv_start == 0, "R1 conv_start", int'(conv_start), 0);
    chk(eoc == 1, "R1 eoc", int'(eoc), 1);
    chk(xtrig == 0, "R1 xtrig", int'(xtrig), 0);
    rst_n = 1'b1;
    ncyc(2);
    // R1 reset config: pacing software, trigger off -> no start
    sw_pulse(); ncyc(8);
    chk(nstart == 0, "R1 default trigger off", nstart, 0);

    // R2 R3 R4: sweep every first/last pair in both modes, software paced
    for (int md = 0; md < 2; md++) begin
      int n;
      n = (md == 1) ? 16 : 8;
      for (int lo = 0; lo < n; lo++) begin
        for (int hi = 0; hi < n; hi++) begin
          int s0, bad, bad_k, bad_a, bad_e;
          cfg(lo, hi, md[0], 0, 1, 0);
          ncyc(1);
          chk(int'(mux_addr) == lo, "R2 load first channel", int'(mux_addr), lo);
          s0 = nstart; bad = 0; bad_k = 0; bad_a = 0; bad_e = 0;
          for (int k = 0; k < 18; k++) begin
            sw_pulse(); ncyc(8);
            if (bad == 0 && last_addr != ring_ch(lo, hi, k, n)) begin
              bad = 1; bad_k = k; bad_a = last_addr; bad_e = ring_ch(lo, hi, k, n);
            end
          end
          chk(bad == 0, "R3 scan order", bad_a, bad_e);
          chk(nstart - s0 == 18, "R4 one start per write", nstart - s0, 18);
        end
      end
    end

    // R2 differential masks the top bit of the first channel
    cfg(10, 3, 1'b0, 0, 1, 0); ncyc(1);
    chk(mux_addr == 2, "R2 differential mask", int'(mux_addr), 2);
    // R3 single-ended wrap 14..1 through the top
    cfg(14, 1, 1'b1, 0, 1, 0); ncyc(1);
    sw_pulse(); ncyc(8); sw_pulse(); ncyc(8); sw_pulse(); ncyc(8);
    chk(last_addr == 0, "R3 wrap through top", last_addr, 0);

    // R9 busy window drops pacing events
    done_lat = 20;
    cfg(0, 7, 1'b1, 0, 1, 0);
    begin
      int s0;
      s0 = nstart;
      sw_pulse(); ncyc(3);
      chk(eoc == 0, "R9 eoc busy", int'(eoc), 0);
      sw_pulse(); ncyc(30);
      chk(nstart - s0 == 1, "R9 dropped while busy", nstart - s0, 1);
      chk(eoc == 1, "R9 eoc done", int'(eoc), 1);
      chk(mux_addr == 1, "R3 advance after done", int'(mux_addr), 1);
    end
    done_lat = 2;

    // R7 trigger codes 00 and 11 block
    begin
      int s0;
      cfg(0, 3, 1'b1, 0, 0, 0); s0 = nstart;
      sw_pulse(); ncyc(8);
      chk(nstart == s0, "R7 trigger 00 blocks", nstart - s0, 0);
      cfg(0, 3, 1'b1, 0, 3, 0);
      sw_pulse(); ncyc(8);
      chk(nstart == s0, "R7 trigger 11 blocks", nstart - s0, 0);
    end

    // R5 internal divider 3 x 4 = 12 ticks
    cfg(0, 15, 1'b1, 0, 0, 0);
    div_put(0, 3); div_put(0, 0); div_put(1, 4); div_put(1, 0);
    begin
      int s0;
      cfg(0, 15, 1'b1, 1, 1, 0);
      ncyc(30); clear_iv(); s0 = nstart;
      ncyc(240);
      chk(min_iv == 12 && max_iv == 12, "R5 divider period", min_iv, 12);
      chk(nstart - s0 >= 19, "R5 divider count", nstart - s0, 20);
      // R10 divider 1 x 2 gives events every 2 cycles; spacing clamps to GAP
      cfg(0, 15, 1'b1, 0, 0, 0);
      div_put(0, 1); div_put(0, 0); div_put(1, 2); div_put(1, 0);
      cfg(0, 15, 1'b1, 1, 1, 0);
      ncyc(20); clear_iv();
      ncyc(120);
      chk(min_iv == GAP && max_iv == GAP, "R10 minimum spacing", min_iv, GAP);
      cfg(0, 15, 1'b1, 0, 0, 0);
      ncyc(10);
    end

    // R6 external rising edges
    begin
      int s0, s1;
      cfg(0, 15, 1'b1, 3, 1, 0); s0 = nstart;
      for (int i = 0; i < 4; i++) begin
        ext_pace = 1'b1; ncyc(12); ext_pace = 1'b0; ncyc(12);
      end
      chk(nstart - s0 == 4, "R6 rising edges", nstart - s0, 4);
      // R6 falling edges: no start after the rise, one after the fall
      cfg(0, 15, 1'b1, 2, 1, 0); s0 = nstart; s1 = 0;
      for (int i = 0; i < 4; i++) begin
        ext_pace = 1'b1; ncyc(12);
        if (nstart != s0 + i) s1 = 1;
        ext_pace = 1'b0; ncyc(12);
      end
      chk(s1 == 0, "R6 rise ignored in falling mode", s1, 0);
      chk(nstart - s0 == 4, "R6 falling edges", nstart - s0, 4);
    end

    // R8 external one-shot trigger
    begin
      int s0;
      cfg(0, 15, 1'b1, 0, 2, 1); s0 = nstart;
      sw_pulse(); ncyc(8);
      chk(nstart == s0, "R8 blocked before trigger", nstart - s0, 0);
      chk(xtrig == 0, "R8 latch clear", int'(xtrig), 0);
      ext_trig = 1'b1; ncyc(6); ext_trig = 1'b0; ncyc(4);
      chk(xtrig == 1, "R8 latch set", int'(xtrig), 1);
      sw_pulse(); ncyc(8);
      chk(nstart - s0 == 1, "R8 runs after trigger", nstart - s0, 1);
      ext_trig = 1'b1; ncyc(6); ext_trig = 1'b0; ncyc(4);
      chk(xtrig == 1, "R8 later edge ignored", int'(xtrig), 1);
      @(negedge clk); xtrig_clr = 1'b1; @(negedge clk); xtrig_clr = 1'b0;
      chk(xtrig == 0, "R8 cleared", int'(xtrig), 0);
      sw_pulse(); ncyc(8);
      chk(nstart - s0 == 1, "R8 blocked after clear", nstart - s0, 1);
      cfg(0, 15, 1'b1, 0, 2, 0);
      ext_trig = 1'b1; ncyc(6); ext_trig = 1'b0; ncyc(4);
      chk(xtrig == 0, "R8 enable off", int'(xtrig), 0);
    end

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule